// File: doc/BRIEF.md
# Cache Line Zeroing Sequencer

This block is the control path of a small direct-mapped data cache that can clear one whole cache line in a single operation. A zeroing request carries an effective address. The block drives one bus write per beat of the addressed line, each carrying zero data. As each bus acknowledge returns, it writes zero into the matching word of the cache data RAM. When the last acknowledge has arrived, the line is valid in the cache under the request's tag and holds all zeroes, both in memory and in the cache.

The zeroing operation uses the same state sequence as a load miss, which the block also provides. On a load miss the line is refilled with bus reads, and the requested word is returned when the operation completes. A load hit is answered from the data RAM with no bus traffic. The zeroing operation differs from a load miss in only two ways. Its bus cycles are writes carrying zero, and it fills the cache with zeroes instead of returned data. If the line is already resident, it stays valid and is overwritten in place. Otherwise it is allocated.

A separate read-only probe port looks up any address and returns its hit status and the cached word one cycle later. Surrounding logic and the bench use it to observe the cache while an operation is running. With default parameters the bus is 64 bits wide and a line is 64 bytes, so one operation takes eight beats.

Top module: `line_zero_unit`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `bus_cyc` and `bus_stb` are low, and every probe misses.
- R2: A zeroing request (`req_zero`=1) issues exactly 8 write strobes (`bus_we`=1). They go to addresses base+0, base+8, …, base+56 in ascending order, where base is `req_addr` with its low 6 bits cleared, so those 6 bits have no effect.
- R3: Every write strobe of a zeroing operation carries `bus_wdata` equal to zero.
- R4: After a zeroing operation, a probe of each of the line's 8 words hits and returns zero.
- R5: A zeroing request to a line that is not resident allocates it, and the line is valid at completion. A line that held the same index under another tag then misses. Lines at other indices keep their contents.
- R6: A zeroing request to a resident line overwrites that line's previously loaded data with zeroes. No memory word outside the addressed line is written.
- R7: While a resident line is being zeroed, probes of that line keep hitting throughout the operation.
- R8: `done` is high for exactly one cycle, in the cycle right after the cycle whose acknowledge was the last of the line. `busy` is high from the cycle after acceptance through the `done` cycle. A request presented while `busy` is high is ignored and causes no bus traffic and no further `done`.
- R9: A load miss (`req_zero`=0) runs the same 8-beat ascending sequence with reads (`bus_we`=0). It fills the line with the returned data, keeps the line invalid until the last acknowledge, and shows the requested 64-bit word on `resp_data` while `done` is high.
- R10: A load hit issues no bus strobe. `done` rises in the second cycle after the request is accepted, with the cached word on `resp_data`.
- R11: While `bus_stall` is high, a pending strobe is held with an unchanged address. `bus_cyc` stays high until all 8 acknowledges have returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_zero | input | 1 | 1 = zero the line, 0 = load a word |
| req_addr | input | 32 | Effective byte address of the request |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_data | output | 64 | Loaded word while `done` is high (zero for a zeroing request) |
| probe_addr | input | 32 | Byte address to look up |
| probe_hit | output | 1 | Registered hit result for `probe_addr` |
| probe_data | output | 64 | Registered cached word for `probe_addr` |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Beat request strobe |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | 32 | Byte address of the current beat |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` |
| bus_stall | input | 1 | Slave cannot take the strobe this cycle |
| bus_ack | input | 1 | One beat completed |

## Verification
The assertions assume the slave answers in strobe order. They also assume it raises `bus_ack` only while `bus_cyc` is high and never returns more acknowledges than it has accepted strobes, so that an ack count of eight marks the end of a line. The bench's memory model keeps accepted strobes in a FIFO and pops exactly one entry per acknowledge after a random delay. Its stall input is randomised per cycle, so every acknowledge has a matching strobe and order is preserved. Requests are driven only from the bench's own tasks. The single request made while busy is there on purpose, to show that it is dropped.

// File: rtl/czs_pkg.sv
package czs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2,
        ST_DONE = 2'd3
    } czs_state_e;

    typedef enum logic {
        OP_LOAD = 1'b0,
        OP_ZERO = 1'b1
    } czs_op_e;

    typedef struct packed {
        czs_op_e op;
        logic    hit;
        logic    from_arr;
    } czs_ctl_t;

    // A load refill keeps the line hidden; a zeroing pass may leave it visible.
    function automatic logic refill_hides_line(czs_op_e op, logic was_hit);
        return (op == OP_LOAD) || !was_hit;
    endfunction

    // Only a load that hit can skip the bus sequence.
    function automatic logic needs_bus(czs_op_e op, logic hit);
        return !((op == OP_LOAD) && hit);
    endfunction

endpackage

// File: rtl/czs_bus_seq.sv
module czs_bus_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     start_we,
    input  logic [ADDR_W-1:0]        start_base,
    input  logic                     bus_stall,
    input  logic                     bus_ack,
    output logic                     bus_cyc,
    output logic                     bus_stb,
    output logic                     bus_we,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic                     beat_ack,
    output logic [$clog2(BEATS)-1:0] beat_idx,
    output logic                     beat_last
);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int CNT_W  = BEAT_W + 1;
    localparam int BOFF_W = $clog2(DATA_W / 8);

    logic              active;
    logic              we_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  issued;
    logic [CNT_W-1:0]  acked;

    assign bus_cyc   = active;
    assign bus_stb   = active && (issued != CNT_W'(BEATS));
    assign bus_we    = we_q;
    assign bus_addr  = base_q | (ADDR_W'(issued[BEAT_W-1:0]) << BOFF_W);
    assign beat_ack  = active && bus_ack;
    assign beat_idx  = acked[BEAT_W-1:0];
    assign beat_last = beat_ack && (acked == CNT_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            we_q   <= 1'b0;
            base_q <= '0;
            issued <= '0;
            acked  <= '0;
        end else if (start) begin
            active <= 1'b1;
            we_q   <= start_we;
            base_q <= start_base;
            issued <= '0;
            acked  <= '0;
        end else begin
            if (bus_stb && !bus_stall) issued <= issued + 1'b1;
            if (beat_ack)              acked  <= acked + 1'b1;
            if (beat_last)             active <= 1'b0;
        end
    end
endmodule

// File: rtl/czs_tag_array.sv
module czs_tag_array #(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 22
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [$clog2(NUM_LINES)-1:0] wr_idx,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic                         wr_vld,
    input  logic [$clog2(NUM_LINES)-1:0] lk_idx,
    output logic [TAG_W-1:0]             lk_tag,
    output logic                         lk_vld,
    input  logic [$clog2(NUM_LINES)-1:0] pr_idx,
    output logic [TAG_W-1:0]             pr_tag,
    output logic                         pr_vld
);
    logic [TAG_W-1:0]     tags [NUM_LINES];
    logic [NUM_LINES-1:0] vld;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                vld[g] <= 1'b0;
            else if (wr_en && (wr_idx == g))
                vld[g] <= wr_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tags[wr_idx] <= wr_tag;
    end

    assign lk_tag = tags[lk_idx];
    assign lk_vld = vld[lk_idx];
    assign pr_tag = tags[pr_idx];
    assign pr_vld = vld[pr_idx];
endmodule

// File: rtl/czs_data_array.sv
module czs_data_array #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 128
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_q,
    input  logic [$clog2(DEPTH)-1:0] pr_addr,
    output logic [DATA_W-1:0]        pr_q
);
    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_addr] <= wr_data;
        rd_q <= words[rd_addr];
        pr_q <= words[pr_addr];
    end
endmodule

// File: rtl/line_zero_unit.sv
module line_zero_unit
    import czs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 64,
    parameter int NUM_LINES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_zero,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] resp_data,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic [DATA_W-1:0] probe_data,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_stall,
    input  logic              bus_ack
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int BOFF_W     = $clog2(BEAT_BYTES);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
    localparam int WORDS      = NUM_LINES * BEATS;

    czs_state_e        state;
    czs_ctl_t          ctl;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] cap_q;
    logic              probe_hit_q;

    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [BEAT_W-1:0] want_beat;
    logic [ADDR_W-1:0] line_base;

    assign idx_q     = addr_q[OFF_W +: IDX_W];
    assign tag_q     = addr_q[ADDR_W-1 -: TAG_W];
    assign want_beat = addr_q[BOFF_W +: BEAT_W];
    assign line_base = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // tag array wiring
    logic [TAG_W-1:0]  lk_tag, pr_tag;
    logic              lk_vld, pr_vld, lk_hit;
    logic              tag_wr_en, tag_wr_vld;
    logic [IDX_W-1:0]  pr_idx;
    logic [TAG_W-1:0]  pr_tag_want;

    assign pr_idx      = probe_addr[OFF_W +: IDX_W];
    assign pr_tag_want = probe_addr[ADDR_W-1 -: TAG_W];
    assign lk_hit      = lk_vld && (lk_tag == tag_q);

    // bus sequencer wiring
    logic              seq_start;
    logic              beat_ack, beat_last;
    logic [BEAT_W-1:0] beat_idx;

    // data array wiring
    logic              dat_wr_en;
    logic [DATA_W-1:0] dat_wr_data;
    logic [DATA_W-1:0] rd_q;

    // status views shared with the checker
    logic op_is_zero, in_fill;
    assign op_is_zero = (ctl.op == OP_ZERO);
    assign in_fill    = (state == ST_FILL);

    assign seq_start   = (state == ST_LOOK) && needs_bus(ctl.op, lk_hit);
    assign tag_wr_en   = ((state == ST_LOOK) && !lk_hit) || (in_fill && beat_last);
    assign tag_wr_vld  = in_fill;
    assign dat_wr_en   = in_fill && beat_ack;
    assign dat_wr_data = op_is_zero ? '0 : bus_rdata;

    czs_tag_array #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tag_wr_en),
        .wr_idx (idx_q),
        .wr_tag (tag_q),
        .wr_vld (tag_wr_vld),
        .lk_idx (idx_q),
        .lk_tag (lk_tag),
        .lk_vld (lk_vld),
        .pr_idx (pr_idx),
        .pr_tag (pr_tag),
        .pr_vld (pr_vld)
    );

    czs_data_array #(
        .DATA_W (DATA_W),
        .DEPTH  (WORDS)
    ) u_data (
        .clk     (clk),
        .wr_en   (dat_wr_en),
        .wr_addr ({idx_q, beat_idx}),
        .wr_data (dat_wr_data),
        .rd_addr ({idx_q, want_beat}),
        .rd_q    (rd_q),
        .pr_addr ({pr_idx, probe_addr[BOFF_W +: BEAT_W]}),
        .pr_q    (probe_data)
    );

    czs_bus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (seq_start),
        .start_we   (op_is_zero),
        .start_base (line_base),
        .bus_stall  (bus_stall),
        .bus_ack    (bus_ack),
        .bus_cyc    (bus_cyc),
        .bus_stb    (bus_stb),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .beat_ack   (beat_ack),
        .beat_idx   (beat_idx),
        .beat_last  (beat_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ctl         <= '{op: OP_LOAD, hit: 1'b0, from_arr: 1'b0};
            addr_q      <= '0;
            cap_q       <= '0;
            probe_hit_q <= 1'b0;
        end else begin
            probe_hit_q <= pr_vld && (pr_tag == pr_tag_want);
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        ctl.op <= req_zero ? OP_ZERO : OP_LOAD;
                        state  <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    ctl.hit <= lk_hit;
                    if (needs_bus(ctl.op, lk_hit)) begin
                        ctl.from_arr <= 1'b0;
                        state        <= ST_FILL;
                    end else begin
                        ctl.from_arr <= 1'b1;
                        state        <= ST_DONE;
                    end
                end
                ST_FILL: begin
                    if (beat_ack && !op_is_zero && (beat_idx == want_beat))
                        cap_q <= bus_rdata;
                    if (beat_last)
                        state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign bus_wdata = '0;
    assign probe_hit = probe_hit_q;
    assign resp_data = op_is_zero ? '0 : (ctl.from_arr ? rd_q : cap_q);

endmodule

// File: rtl/czs_chk.sv
module czs_chk #(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cyc,
    input logic              bus_stb,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_stall,
    input logic              bus_ack,
    input logic              busy,
    input logic              done,
    input logic              op_zero,
    input logic              in_fill,
    input logic              was_hit,
    input logic              line_vld
);
    logic [7:0] ack_cnt;
    logic [7:0] stb_cnt;

    always_ff @(posedge clk) begin
        if (rst || done) begin
            ack_cnt <= '0;
            stb_cnt <= '0;
        end else begin
            if (bus_ack)               ack_cnt <= ack_cnt + 1'b1;
            if (bus_stb && !bus_stall) stb_cnt <= stb_cnt + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_cyc);

    p_zero_writes_r2: assert property (@(posedge clk) disable iff (rst)
        bus_stb && op_zero |-> bus_we);

    p_zero_beats_r2: assert property (@(posedge clk) disable iff (rst)
        done && op_zero |-> (ack_cnt == 8'(BEATS)) && (stb_cnt == 8'(BEATS)));

    p_resident_kept_r7: assert property (@(posedge clk) disable iff (rst)
        in_fill && op_zero && was_hit |-> line_vld);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy && !bus_cyc);

    p_load_reads_r9: assert property (@(posedge clk) disable iff (rst)
        bus_stb && !op_zero |-> !bus_we);

    p_refill_hidden_r9: assert property (@(posedge clk) disable iff (rst)
        in_fill && !op_zero |-> !line_vld);

    p_done_count_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (ack_cnt == 8'(BEATS)) || (ack_cnt == 8'd0));

    p_stb_in_cyc_r11: assert property (@(posedge clk) disable iff (rst)
        bus_stb |-> bus_cyc);

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        bus_stb && bus_stall |=> bus_stb && $stable(bus_addr));

endmodule

bind line_zero_unit czs_chk #(
    .ADDR_W (ADDR_W),
    .BEATS  (BEATS)
) u_czs_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_stall (bus_stall),
    .bus_ack   (bus_ack),
    .busy      (busy),
    .done      (done),
    .op_zero   (op_is_zero),
    .in_fill   (in_fill),
    .was_hit   (ctl.hit),
    .line_vld  (lk_vld)
);

// File: tb/tb_line_zero_unit.sv
`timescale 1ns/1ps
module tb_line_zero_unit;
    localparam int MWORDS = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_zero = 1'b0;
    logic [31:0] req_addr = '0;
    logic        busy, done;
    logic [63:0] resp_data;
    logic [31:0] probe_addr = '0;
    logic        probe_hit;
    logic [63:0] probe_data;
    logic        bus_cyc, bus_stb, bus_we;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata = '0;
    logic        bus_stall = 1'b0;
    logic        bus_ack = 1'b0;

    always #2 clk = ~clk;

    line_zero_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_zero(req_zero),
        .req_addr(req_addr), .busy(busy), .done(done), .resp_data(resp_data),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_data(probe_data),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_stall(bus_stall),
        .bus_ack(bus_ack)
    );

    int nchecks = 0;
    int nerrs   = 0;
    bit finished = 0;

    logic [63:0] mem  [MWORDS];
    logic [63:0] gold [MWORDS];

    // memory model state
    int          cyc = 0;
    int          last_ack_cyc = 0;
    logic [31:0] f_addr [16];
    logic        f_we   [16];
    logic [63:0] f_dat  [16];
    int          f_rdy  [16];
    int          f_head = 0, f_tail = 0, f_cnt = 0;
    logic [31:0] log_addr [32];
    logic        log_we   [32];
    logic [63:0] log_wd   [32];
    int          log_n = 0;
    bit          stall_en = 0;
    int          max_dly = 0;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            bus_ack = 1'b0;
            if (f_cnt > 0 && cyc >= f_rdy[f_head]) begin
                bus_ack = 1'b1;
                if (f_we[f_head]) mem[f_addr[f_head][11:3]] = f_dat[f_head];
                bus_rdata = mem[f_addr[f_head][11:3]];
                last_ack_cyc = cyc;
                f_head = (f_head + 1) % 16;
                f_cnt--;
            end
            bus_stall = stall_en ? ($urandom_range(0, 2) == 0) : 1'b0;
            if (bus_stb && !bus_stall) begin
                f_addr[f_tail] = bus_addr;
                f_we[f_tail]   = bus_we;
                f_dat[f_tail]  = bus_wdata;
                f_rdy[f_tail]  = cyc + 1 + $urandom_range(0, max_dly);
                f_tail = (f_tail + 1) % 16;
                f_cnt++;
                if (log_n < 32) begin
                    log_addr[log_n] = bus_addr;
                    log_we[log_n]   = bus_we;
                    log_wd[log_n]   = bus_wdata;
                end
                log_n++;
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input bit zero, input logic [31:0] a);
        req_valid = 1'b1;
        req_zero  = zero;
        req_addr  = a;
        step();
        req_valid = 1'b0;
    endtask

    task automatic check_memory(input string req);
        int bad = 0;
        for (int i = 0; i < MWORDS; i++)
            if (mem[i] !== gold[i]) bad++;
        chk(req, "memory words differing from expected", 64'(bad), 64'd0);
    endtask

    task automatic check_line(input string req, input logic [31:0] base,
                              input bit exp_hit);
        for (int i = 0; i < 8; i++) begin
            probe_addr = base + 32'(8 * i);
            step();
            chk(req, "probe hit", {63'd0, probe_hit}, {63'd0, exp_hit});
            if (exp_hit)
                chk(req, "probe data", probe_data, gold[(base >> 3) + i]);
        end
    endtask

    task automatic check_log(input string req, input logic [31:0] base,
                             input bit exp_we);
        chk(req, "beat count", 64'(log_n), 64'd8);
        for (int i = 0; i < 8 && i < log_n; i++) begin
            chk(req, "beat address", 64'(log_addr[i]), 64'(base + 32'(8 * i)));
            chk(req, "beat direction", {63'd0, log_we[i]}, {63'd0, exp_we});
            if (exp_we) chk("R3", "write data", log_wd[i], 64'd0);
        end
    endtask

    // load a word, expecting hit or miss
    task automatic load_word(input logic [31:0] a, input bit exp_hit);
        int k = 0;
        logic [31:0] base = a & ~32'h3F;
        log_n = 0;
        send(1'b0, a);
        while (!done && k < 400) begin step(); k++; end
        if (exp_hit) begin
            chk("R10", "resp_data on hit", resp_data, gold[a[11:3]]);
            chk("R10", "cycles to done", 64'(k), 64'd1);
            chk("R10", "bus strobes on hit", 64'(log_n), 64'd0);
        end else begin
            chk("R9", "resp_data on miss", resp_data, gold[a[11:3]]);
            check_log("R9", base, 1'b0);
            chk("R9", "done after last ack", 64'(cyc), 64'(last_ack_cyc + 1));
        end
        step();
        chk("R8", "done width", {63'd0, done}, 64'd0);
    endtask

    // zero a line; resident selects the in-flight probe check
    task automatic zero_line(input logic [31:0] a, input bit resident,
                             input bit inject, input string req);
        int k = 0;
        int miss_during = 0;
        logic [31:0] base = a & ~32'h3F;
        log_n = 0;
        probe_addr = base;
        send(1'b1, a);
        chk("R8", "busy after accept", {63'd0, busy}, 64'd1);
        while (!done && k < 400) begin
            if (resident && !probe_hit) miss_during++;
            if (inject && k == 1) begin
                req_valid = 1'b1; req_zero = 1'b0; req_addr = 32'h0000_0E08;
            end else begin
                req_valid = 1'b0;
            end
            step();
            k++;
        end
        req_valid = 1'b0;
        if (resident) chk("R7", "probe misses during zeroing", 64'(miss_during), 64'd0);
        chk("R8", "done after last ack", 64'(cyc), 64'(last_ack_cyc + 1));
        chk("R8", "busy with done", {63'd0, busy}, 64'd1);
        check_log("R2", base, 1'b1);
        for (int i = 0; i < 8; i++) gold[(base >> 3) + i] = 64'd0;
        step();
        chk("R8", "done width", {63'd0, done}, 64'd0);
        chk("R8", "busy after done", {63'd0, busy}, 64'd0);
        if (inject) begin
            step(); step(); step();
            chk("R8", "busy after ignored request", {63'd0, busy}, 64'd0);
            chk("R8", "bus beats after ignored request", 64'(log_n), 64'd8);
        end
        check_memory(req);
        check_line("R4", base, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < MWORDS; i++) begin
            mem[i]  = {16'hC0DE, 16'(i), 32'(i) * 32'h0101_0101 + 32'd7};
            gold[i] = mem[i];
        end
        repeat (4) step();
        rst = 1'b0;
        step();
        // R1: reset state
        chk("R1", "busy", {63'd0, busy}, 64'd0);
        chk("R1", "done", {63'd0, done}, 64'd0);
        chk("R1", "bus_cyc", {63'd0, bus_cyc}, 64'd0);
        chk("R1", "bus_stb", {63'd0, bus_stb}, 64'd0);
        check_line("R1", 32'h0000_01C0, 1'b0);

        // R9 / R10: refill and hit
        max_dly = 2;
        load_word(32'h0000_01C8, 1'b0);
        load_word(32'h0000_01D0, 1'b1);
        check_line("R9", 32'h0000_01C0, 1'b1);
        load_word(32'h0000_0080, 1'b0);

        // R6 / R7: zero a resident line, odd low address bits
        stall_en = 1; max_dly = 3;
        zero_line(32'h0000_01C0 + 32'h15, 1'b1, 1'b0, "R6");
        check_line("R5", 32'h0000_0080, 1'b1);

        // R5: allocate a non-resident line
        max_dly = 0; stall_en = 0;
        zero_line(32'h0000_0300, 1'b0, 1'b0, "R5");
        load_word(32'h0000_0318, 1'b1);

        // R5 / R8 / R11: evict by conflict under heavy stall, with ignored request
        stall_en = 1; max_dly = 5;
        zero_line(32'h0000_05FF, 1'b0, 1'b1, "R11");
        check_line("R5", 32'h0000_01C0, 1'b0);
        check_line("R5", 32'h0000_0080, 1'b1);
        check_line("R5", 32'h0000_0300, 1'b1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerrs++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
            $finish;
        end
    end
endmodule